// File: doc/BRIEF.md
# Serial ADC readout master

This block is a host-side serial master for a converter whose single output line does two jobs: it is an active-low "result ready" flag while the converter is idle and selected, and it is the shifted data once a read is in progress. A read transaction selects the converter and polls that line until it goes low, bounded by a programmable timeout. It then clocks out an 8-bit read command and clocks in a 24-bit result, most significant bit first. A write transaction sends a command byte followed by 24 data bits and does not wait for ready.

The host starts a transfer with a one-cycle `start_i` pulse. It holds `busy_o` until the end and receives a one-cycle `done_o`. The result is on `rdata_o`, with `err_o` (ready never came) and `stale_o` (the read did not follow a fresh ready-low). Every serial time limit is derived from a parameter giving the system clock period in nanoseconds, rounded up to whole cycles. The SCLK half period is programmable and is never allowed below the minimum pulse width. SCLK idles high (SPI mode 3). The master drives MOSI on SCLK falling edges and samples MISO on rising edges.

Top module: `adcrd_master`

## Requirements
- R1: After reset `cs_n_o`=1, `sclk_o`=1, `busy_o`=0, `done_o`=0, `err_o`=0, `stale_o`=0, `rdata_o`=0; whenever `cs_n_o` is 1, `sclk_o` is 1.
- R2: Each SCLK low phase and each high phase inside a frame lasts max(`half_i`, ceil(25/CLK_NS)) system clocks; with CLK_NS=4 the minimum is 7.
- R3: The first SCLK falling edge comes no sooner than ceil(40/CLK_NS) clocks after `cs_n_o` falls (10 at 4 ns). For writes and ready-skipping reads the gap is exactly that value.
- R4: MOSI changes only together with an SCLK falling edge and is stable across each high phase. The frame is the command byte {1'b0, rd, addr[5:0]} (bit 6 = 1 for read) followed by 24 data bits, all MSB first.
- R5: A normal read waits for MISO low, then gives 32 SCLK rising edges. `rdata_o` holds the last 24 bits sampled on rising edges, first sampled bit as MSB.
- R6: A write sends bit 6 = 0 and `wdata_i` MSB first without waiting for ready. It leaves `rdata_o` unchanged.
- R7: If MISO stays high for `timeout_i` clocks of polling, the transaction ends with no SCLK edge, `err_o`=1 and `rdata_o` unchanged. `err_o` is cleared by the next start.
- R8: With `skip_wait_i`=1 a read samples MISO once at the end of the settle time and then transfers at once. `stale_o` is set at completion when no read has seen MISO low since the previous completed read; otherwise it is cleared.
- R9: `cs_n_o` rises ceil(5/CLK_NS)=2 clocks after the last high phase ends (H+2 clocks after the last rising edge). `done_o` is a single-cycle pulse ceil(20/CLK_NS)=5 clocks after `cs_n_o` rises, in the same cycle `busy_o` falls.
- R10: `start_i` is ignored while `busy_o` is 1; the transfer in progress is unchanged and only one `done_o` results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse, taken when idle |
| write_i | input | 1 | 1 = write transfer, 0 = read |
| skip_wait_i | input | 1 | Read without polling for ready |
| addr_i | input | 6 | Register address in the command byte |
| wdata_i | input | 24 | Write data |
| half_i | input | 8 | Requested SCLK half period in clocks |
| timeout_i | input | 16 | Ready polling limit in clocks |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 24 | Last read result |
| err_o | output | 1 | Ready timeout on the last transfer |
| stale_o | output | 1 | Last read had no fresh ready-low |
| cs_n_o | output | 1 | Chip select, active low |
| sclk_o | output | 1 | Serial clock, idles high |
| mosi_o | output | 1 | Serial data to converter |
| miso_i | input | 1 | Shared data / ready-low line |

## Verification
A wrong bit count shows within the same frame as a missing or extra SCLK rising edge before `cs_n_o` rises. It also shows as a command or write word the converter model captures shifted by one place. A wrong timer load shows as a phase width, settle gap, hold gap or release gap that differs from its computed value on the first edge it governs. A state machine stuck between states shows as `busy_o` never falling. A freshness flag left wrong shows only at the end of the following ready-skipping read, as a wrong `stale_o`.

// File: rtl/adcrd_pkg.sv
// Shared types and helpers for the serial ADC readout master.
package adcrd_pkg;

    // Transaction sequencer states.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_WAIT,
        ST_SHIFT,
        ST_HOLD,
        ST_REL
    } adcrd_st_t;

    // Nanoseconds to whole system clocks, rounded up.
    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

endpackage

// File: rtl/adcrd_timer.sv
// Down-counting interval timer.
// A load of N makes zero_o true N-1 clocks later, so a state that waits for
// zero_o and reloads on leaving lasts exactly N clocks. A load of 0 acts as 1.
module adcrd_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_q;

    // Load or count down toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= (val_i == '0) ? '0 : val_i - W'(1);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - W'(1);
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/adcrd_shifter.sv
// Frame shift register: command plus data out on MOSI, samples in from MISO.
// drive_i updates MOSI from the MSB (falling edge); sample_i shifts MISO into
// the LSB (rising edge). Assumes drive and sample alternate, drive first.
module adcrd_shifter #(
    parameter int CMD_W  = 8,
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [CMD_W-1:0]  cmd_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              drive_i,
    input  logic              sample_i,
    input  logic              miso_i,
    output logic              mosi_o,
    output logic [DATA_W-1:0] data_o,
    output logic              last_o
);
    localparam int FRAME_W = CMD_W + DATA_W;
    localparam int CW      = $clog2(FRAME_W + 1);

    logic [FRAME_W-1:0] sreg_q;
    logic [CW-1:0]      nbit_q;
    logic               mosi_q;

    // Frame register and sampled-bit count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg_q <= '0;
            nbit_q <= '0;
        end else if (load_i) begin
            sreg_q <= {cmd_i, wdata_i};
            nbit_q <= '0;
        end else if (sample_i) begin
            sreg_q <= {sreg_q[FRAME_W-2:0], miso_i};
            nbit_q <= nbit_q + CW'(1);
        end
    end

    // MOSI moves only on a drive strobe; idles high.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mosi_q <= 1'b1;
        else if (drive_i)
            mosi_q <= sreg_q[FRAME_W-1];
    end

    assign mosi_o = mosi_q;
    assign data_o = sreg_q[DATA_W-1:0];
    assign last_o = (nbit_q == CW'(FRAME_W));
endmodule

// File: rtl/adcrd_master.sv
// Serial ADC readout master (SPI mode 3, shared data/ready-low line).
// Sequence: select -> settle -> (poll ready) -> 32-bit frame -> hold ->
// release. All serial timing is counted in system clocks derived from CLK_NS.
// Assumes miso_i is already synchronous to clk.
module adcrd_master
    import adcrd_pkg::*;
#(
    parameter int CLK_NS      = 4,
    parameter int SCLK_MIN_NS = 25,
    parameter int SETTLE_NS   = 40,
    parameter int CS_HOLD_NS  = 5,
    parameter int BUS_FREE_NS = 20,
    parameter int ADDR_W      = 6,
    parameter int DATA_W      = 24,
    parameter int HALF_W      = 8,
    parameter int TMO_W       = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              write_i,
    input  logic              skip_wait_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [HALF_W-1:0] half_i,
    input  logic [TMO_W-1:0]  timeout_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              err_o,
    output logic              stale_o,
    output logic              cs_n_o,
    output logic              sclk_o,
    output logic              mosi_o,
    input  logic              miso_i
);
    localparam int CMD_W        = ADDR_W + 2;
    localparam int TW           = (HALF_W > TMO_W) ? HALF_W : TMO_W;
    localparam int MIN_HALF_CYC = ns_to_cyc(SCLK_MIN_NS, CLK_NS);
    localparam int SETTLE_CYC   = ns_to_cyc(SETTLE_NS, CLK_NS);
    localparam int HOLD_CYC     = ns_to_cyc(CS_HOLD_NS, CLK_NS);
    localparam int FREE_CYC     = ns_to_cyc(BUS_FREE_NS, CLK_NS);

    adcrd_st_t         st_q, st_d;
    logic              wr_q, skip_q, fresh_q;
    logic [HALF_W-1:0] half_q;
    logic [TMO_W-1:0]  tmo_q;
    logic [TW-1:0]     half_eff, tmr_val;
    logic              tmr_ld, tmr_zero;
    logic              sh_load, sh_drive, sh_sample, sh_last;
    logic [DATA_W-1:0] sh_data;
    logic [CMD_W-1:0]  cmd;

    // Read command carries bit 6 set; bit 7 stays clear.
    assign cmd = {1'b0, ~write_i, addr_i};

    // Clamp the requested half period to the minimum pulse width.
    assign half_eff = (TW'(half_q) < TW'(MIN_HALF_CYC)) ? TW'(MIN_HALF_CYC) : TW'(half_q);

    adcrd_timer #(.W(TW)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_ld),
        .val_i  (tmr_val),
        .zero_o (tmr_zero)
    );

    adcrd_shifter #(.CMD_W(CMD_W), .DATA_W(DATA_W)) u_sh (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (sh_load),
        .cmd_i    (cmd),
        .wdata_i  (wdata_i),
        .drive_i  (sh_drive),
        .sample_i (sh_sample),
        .miso_i   (miso_i),
        .mosi_o   (mosi_o),
        .data_o   (sh_data),
        .last_o   (sh_last)
    );

    // Next state, timer reloads and shift strobes.
    always_comb begin
        st_d      = st_q;
        tmr_ld    = 1'b0;
        tmr_val   = half_eff;
        sh_load   = 1'b0;
        sh_drive  = 1'b0;
        sh_sample = 1'b0;
        case (st_q)
            ST_IDLE: if (start_i) begin
                st_d    = ST_SETTLE;
                tmr_ld  = 1'b1;
                tmr_val = TW'(SETTLE_CYC);
                sh_load = 1'b1;
            end
            ST_SETTLE: if (tmr_zero) begin
                tmr_ld = 1'b1;
                if (!wr_q && !skip_q) begin
                    st_d    = ST_WAIT;
                    tmr_val = TW'(tmo_q);
                end else begin
                    st_d     = ST_SHIFT;
                    sh_drive = 1'b1;
                end
            end
            ST_WAIT: if (!miso_i) begin
                st_d     = ST_SHIFT;
                tmr_ld   = 1'b1;
                sh_drive = 1'b1;
            end else if (tmr_zero) begin
                st_d    = ST_REL;
                tmr_ld  = 1'b1;
                tmr_val = TW'(FREE_CYC);
            end
            ST_SHIFT: if (tmr_zero) begin
                tmr_ld = 1'b1;
                if (!sclk_o) begin
                    sh_sample = 1'b1;
                end else if (sh_last) begin
                    st_d    = ST_HOLD;
                    tmr_val = TW'(HOLD_CYC);
                end else begin
                    sh_drive = 1'b1;
                end
            end
            ST_HOLD: if (tmr_zero) begin
                st_d    = ST_REL;
                tmr_ld  = 1'b1;
                tmr_val = TW'(FREE_CYC);
            end
            ST_REL: if (tmr_zero) st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    // Registered serial pins, host status and transaction settings.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            cs_n_o  <= 1'b1;
            sclk_o  <= 1'b1;
            busy_o  <= 1'b0;
            done_o  <= 1'b0;
            err_o   <= 1'b0;
            stale_o <= 1'b0;
            fresh_q <= 1'b0;
            rdata_o <= '0;
            wr_q    <= 1'b0;
            skip_q  <= 1'b0;
            half_q  <= '0;
            tmo_q   <= '0;
        end else begin
            st_q   <= st_d;
            done_o <= 1'b0;
            if (st_q == ST_IDLE && start_i) begin
                cs_n_o  <= 1'b0;
                busy_o  <= 1'b1;
                err_o   <= 1'b0;
                stale_o <= 1'b0;
                wr_q    <= write_i;
                skip_q  <= skip_wait_i;
                half_q  <= half_i;
                tmo_q   <= timeout_i;
            end
            if (sh_drive)  sclk_o <= 1'b0;
            if (sh_sample) sclk_o <= 1'b1;
            if (st_q == ST_SETTLE && tmr_zero && !wr_q && !miso_i) fresh_q <= 1'b1;
            if (st_q == ST_WAIT && !miso_i) fresh_q <= 1'b1;
            if (st_q == ST_WAIT && miso_i && tmr_zero) begin
                err_o  <= 1'b1;
                cs_n_o <= 1'b1;
            end
            if (st_q == ST_HOLD && tmr_zero) begin
                cs_n_o <= 1'b1;
                if (!wr_q) begin
                    rdata_o <= sh_data;
                    stale_o <= ~fresh_q;
                    fresh_q <= 1'b0;
                end
            end
            if (st_q == ST_REL && tmr_zero) begin
                busy_o <= 1'b0;
                done_o <= 1'b1;
            end
        end
    end
endmodule

// Protocol checker for adcrd_master: pin timing and handshake rules.
// Windows are measured with counters so no delay depends on a parameter.
module adcrd_master_chk #(
    parameter int MIN_HALF = 7,
    parameter int SETTLE   = 10,
    parameter int HOLD     = 2
) (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic busy_o,
    input logic done_o,
    input logic cs_n_o,
    input logic sclk_o,
    input logic mosi_o
);
    logic [15:0] lo_cnt, hi_cnt, sel_cnt;

    // Saturating counts of SCLK low, SCLK high and chip-select-low cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_cnt  <= '0;
            hi_cnt  <= 16'd1000;
            sel_cnt <= '0;
        end else begin
            lo_cnt  <= sclk_o ? 16'd0 : ((lo_cnt == 16'hFFFF) ? lo_cnt : lo_cnt + 16'd1);
            hi_cnt  <= !sclk_o ? 16'd0 : ((hi_cnt == 16'hFFFF) ? hi_cnt : hi_cnt + 16'd1);
            sel_cnt <= cs_n_o ? 16'd0 : ((sel_cnt == 16'hFFFF) ? sel_cnt : sel_cnt + 16'd1);
        end
    end

    assert_sclk_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> sclk_o);
    assert_low_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk_o) |-> lo_cnt >= 16'(MIN_HALF));
    assert_high_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk_o) |-> hi_cnt >= 16'(MIN_HALF));
    assert_settle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk_o) |-> sel_cnt >= 16'(SETTLE));
    assert_mosi_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n_o && sclk_o && $past(sclk_o)) |-> $stable(mosi_o));
    assert_cs_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n_o) |-> (hi_cnt >= 16'(HOLD) && busy_o));
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (cs_n_o && !busy_o) ##1 !done_o);
    assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && !cs_n_o) |=> !cs_n_o || done_o || busy_o);
endmodule

bind adcrd_master adcrd_master_chk #(
    .MIN_HALF (MIN_HALF_CYC),
    .SETTLE   (SETTLE_CYC),
    .HOLD     (HOLD_CYC)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .cs_n_o  (cs_n_o),
    .sclk_o  (sclk_o),
    .mosi_o  (mosi_o)
);

// File: tb/sim_adcrd_master.sv
// Bench for adcrd_master: converter model, vector table, directed tests.
module sim_adcrd_master;
    localparam int MINH   = (25 + 3) / 4;   // ceil(25/4)
    localparam int SETTLE = (40 + 3) / 4;
    localparam int HOLD   = (5 + 3) / 4;
    localparam int FREE   = (20 + 3) / 4;

    typedef struct packed {
        logic        wr;
        logic [5:0]  addr;
        logic [23:0] wdata;
        logic [23:0] word;
        logic        conv;
        logic [7:0]  dly;
        logic        skip;
        logic [7:0]  half;
        logic [15:0] tmo;
        logic        exp_err;
        logic        exp_stale;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 6'h04, 24'h000000, 24'hA5C3F1, 1'b1, 8'd20, 1'b0, 8'd2,  16'd100, 1'b0, 1'b0},
        '{1'b1, 6'h21, 24'h123456, 24'h000000, 1'b0, 8'd0,  1'b0, 8'd9,  16'd100, 1'b0, 1'b0},
        '{1'b0, 6'h04, 24'h000000, 24'h0F00FF, 1'b0, 8'd0,  1'b1, 8'd7,  16'd100, 1'b0, 1'b1},
        '{1'b0, 6'h3F, 24'h000000, 24'h800001, 1'b1, 8'd0,  1'b1, 8'd7,  16'd100, 1'b0, 1'b0},
        '{1'b0, 6'h02, 24'h000000, 24'h555555, 1'b0, 8'd0,  1'b0, 8'd7,  16'd50,  1'b1, 1'b0},
        '{1'b0, 6'h11, 24'h000000, 24'hFFFFFE, 1'b1, 8'd3,  1'b0, 8'd12, 16'd200, 1'b0, 1'b0}
    };

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        start_i = 1'b0, write_i = 1'b0, skip_wait_i = 1'b0;
    logic [5:0]  addr_i = '0;
    logic [23:0] wdata_i = '0;
    logic [7:0]  half_i = '0;
    logic [15:0] timeout_i = '0;
    logic        busy_o, done_o, err_o, stale_o, cs_n_o, sclk_o, mosi_o;
    logic [23:0] rdata_o;
    logic        miso = 1'b1;

    int n_chk = 0, n_fail = 0;

    // Converter model and pin monitor state.
    logic        conv_ready = 1'b0;
    logic [23:0] word = '0;
    int          dly = 0, cyc = 0, falls = 0, rises = 0, since = 1, cs_cnt = 0;
    int          min_hi = 255, min_lo = 255, t_csfall = 0, t_csrise = 0, t_lastrise = 0;
    int          gap_set = 0, gap_hold = 0, gap_rel = 0, done_cnt = 0;
    logic [31:0] cap = '0;
    logic        prev_cs = 1'b1, prev_sclk = 1'b1;

    always #2 clk = ~clk;   // 250 MHz

    adcrd_master u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .write_i(write_i),
        .skip_wait_i(skip_wait_i), .addr_i(addr_i), .wdata_i(wdata_i),
        .half_i(half_i), .timeout_i(timeout_i), .busy_o(busy_o), .done_o(done_o),
        .rdata_o(rdata_o), .err_o(err_o), .stale_o(stale_o), .cs_n_o(cs_n_o),
        .sclk_o(sclk_o), .mosi_o(mosi_o), .miso_i(miso)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Converter model: ready-low after dly, data on falling edges; monitor.
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (!rst_n) begin
                miso = 1'b1; prev_cs = 1'b1; prev_sclk = 1'b1;
            end else begin
                if (prev_cs && !cs_n_o) begin
                    t_csfall = cyc; falls = 0; rises = 0; cap = '0;
                    min_hi = 255; min_lo = 255; since = 1; cs_cnt = 0; gap_set = 0;
                end
                if (!cs_n_o) cs_cnt++;
                if (!prev_cs && cs_n_o) begin
                    t_csrise = cyc; gap_hold = cyc - t_lastrise;
                end
                if (sclk_o != prev_sclk) begin
                    if (!sclk_o) begin
                        falls++;
                        if (falls == 1) gap_set = cyc - t_csfall;
                        else if (since < min_hi) min_hi = since;
                        if (falls >= 9) miso = word[23 - (falls - 9)];
                        else miso = !conv_ready;
                    end else begin
                        rises++;
                        if (since < min_lo) min_lo = since;
                        cap = {cap[30:0], mosi_o};
                        t_lastrise = cyc;
                        if (rises == 32 && cap[30]) conv_ready = 1'b0;
                    end
                    since = 1;
                end else begin
                    since++;
                end
                if (falls == 0 && !cs_n_o) miso = (conv_ready && cs_cnt >= dly) ? 1'b0 : 1'b1;
                if (cs_n_o) miso = 1'b1;
                if (done_o) begin
                    done_cnt++; gap_rel = cyc - t_csrise;
                end
                prev_cs = cs_n_o; prev_sclk = sclk_o;
            end
        end
    end

    task automatic launch(input vec_t v);
        @(negedge clk);
        word = v.word; conv_ready = v.conv; dly = int'(v.dly);
        write_i = v.wr; addr_i = v.addr; wdata_i = v.wdata; skip_wait_i = v.skip;
        half_i = v.half; timeout_i = v.tmo; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_done();
        int guard = 0;
        while (!done_o && guard < 20000) begin
            @(negedge clk); guard++;
        end
        if (!done_o) chk("R9 done timeout", 32'd0, 32'd1);
        @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [23:0] exp_rd = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 cs_n", {31'd0, cs_n_o}, 32'd1);
        chk("R1 sclk", {31'd0, sclk_o}, 32'd1);
        chk("R1 busy/done/err/stale", {28'd0, busy_o, done_o, err_o, stale_o}, 32'd0);
        chk("R1 rdata", {8'd0, rdata_o}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            int h, dc;
            vec_t v;
            v  = VEC[i];
            h  = (int'(v.half) < MINH) ? MINH : int'(v.half);
            dc = done_cnt;
            launch(v);
            chk("R10 busy after start", {31'd0, busy_o}, 32'd1);
            wait_done();
            if (!v.wr && !v.exp_err) exp_rd = v.word;
            chk("R7 err", {31'd0, err_o}, {31'd0, v.exp_err});
            chk("R8 stale", {31'd0, stale_o}, {31'd0, v.exp_stale});
            chk(v.wr ? "R6 rdata kept" : "R5 rdata", {8'd0, rdata_o}, {8'd0, exp_rd});
            chk("R9 one done", done_cnt - dc, 32'd1);
            chk("R9 release gap", gap_rel, FREE);
            if (v.exp_err) begin
                chk("R7 no sclk edge", rises + falls, 32'd0);
            end else begin
                chk("R4 command", {24'd0, cap[31:24]}, {24'd0, 1'b0, ~v.wr, v.addr});
                if (v.wr) chk("R6 write data", {8'd0, cap[23:0]}, {8'd0, v.wdata});
                chk("R5 rising edges", rises, 32'd32);
                chk("R2 low width", min_lo, h);
                chk("R2 high width", min_hi, h);
                if (v.wr || v.skip) chk("R3 settle exact", gap_set, SETTLE);
                else chk("R3 settle min", {31'd0, gap_set >= SETTLE}, 32'd1);
                chk("R9 cs hold", gap_hold, h + HOLD);
            end
        end

        // R10: start during a transfer is ignored.
        begin
            vec_t v;
            int dc;
            v  = '{1'b0, 6'h05, 24'h0, 24'h3C3C3C, 1'b1, 8'd120, 1'b0, 8'd7, 16'd1000, 1'b0, 1'b0};
            dc = done_cnt;
            launch(v);
            repeat (40) @(negedge clk);
            write_i = 1'b1; addr_i = 6'h2A; half_i = 8'd20; start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            wait_done();
            repeat (60) @(negedge clk);
            chk("R10 command unchanged", {24'd0, cap[31:24]}, {24'd0, 8'h45});
            chk("R10 single done", done_cnt - dc, 32'd1);
            chk("R10 idle after", {30'd0, busy_o, cs_n_o}, 32'd1);
            chk("R10 rdata", {8'd0, rdata_o}, {8'd0, 24'h3C3C3C});
        end

        // R1: reset during a ready wait returns the pins to idle.
        begin
            vec_t v;
            v = '{1'b0, 6'h01, 24'h0, 24'h0, 1'b0, 8'd0, 1'b0, 8'd7, 16'd5000, 1'b0, 1'b0};
            launch(v);
            repeat (30) @(negedge clk);
            rst_n = 1'b0;
            repeat (2) @(negedge clk);
            chk("R1 reset mid-transfer", {29'd0, cs_n_o, sclk_o, busy_o}, 32'd6);
            chk("R1 reset rdata", {8'd0, rdata_o}, 32'd0);
            rst_n = 1'b1;
            repeat (2) @(negedge clk);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule